// File: doc/BRIEF.md
# VME Slave Register Decoder

This block sits on the slave side of a readout module attached to a VME bus. Each bus cycle reaches it as a one-clock request. The request carries an address modifier (AM), an address, a direction and write data. The block sorts the cycle by its AM alone.

- **Single-word cycles.** These are 16-bit transfers with AM 0x09 or 0x39. They are decoded against a sparse register map inside a 16 KiB window. The map holds:
  - a fixed module type code;
  - a global scan byte count, supplied by the readout logic;
  - a global status word;
  - a set of writable message registers.
- **Block-transfer cycles.** These use AM 0x0B, 0x08, 0x3B or 0x38. They ignore the address completely. Every block read pops one word from the output data FIFO.

The buffer-number and channel registers check their write values against a range. A value out of range is stored as its low bits, and a sticky error bit is raised in the status word. A block read that finds the FIFO empty returns zero and raises a sticky underrun bit. Any other AM gets no acknowledge, so the bus master can time out.

Top module: `vsd_slave_decoder`

## Requirements
- R1: After reset, `ack` and `fifo_rd` are low. Every message register reads 0. Status bits 1 and 0 read 0.
- R2: A request with AM 0x09 or 0x39 and an address below 0x4000 is acknowledged exactly one clock later. A read returns the register in the low 16 bits of `rdata`, with the upper bits zero. Address bit 0 is ignored. An address of 0x4000 or more gets no acknowledge.
- R3: A read request with AM 0x0B, 0x08, 0x3B or 0x38, at any address and with the FIFO not empty, behaves as follows:
  - it pulses `fifo_rd` in the request cycle;
  - it returns that cycle's `fifo_data` on `rdata` with `ack` one clock later.
- R4: A request with any other AM produces no `ack` and no `fifo_rd`. It changes no register.
- R5: Offset 0x00 reads the type code 3. Writes to it are acknowledged and have no effect.
- R6: Offset 0x04 reads the `scan_bytes` input. Offset 0x06 reads status as follows:
  - bits 15:2 are `hw_status`;
  - bit 1 is the underrun flag;
  - bit 0 is the range-error flag.
  Writes to either offset are acknowledged and ignored.
- R7: The readout buffer register (0x22) and the scan buffer register (0x28) store 5 bits. A written value above 31 is stored as its low 5 bits and sets status bit 0.
- R8: The monitor channel register (0x40) stores 4 bits. A written value above 9 is stored as its low 4 bits and sets status bit 0.
- R9: Offsets 0x24, 0x26, 0x2A and 0x42 are full 16-bit read/write registers.
- R10: Any other offset inside the window is acknowledged. This includes control at 0x02 and the reserved span 0x2C to 0x3E. Reads of these offsets return zero, and writes to them have no effect.
- R11: A block read with the FIFO empty returns zero with `ack`, does not pulse `fifo_rd`, and sets status bit 1.
- R12: A block-transfer write is acknowledged. It does not pulse `fifo_rd` and changes no register.
- R13: Status bits 0 and 1 stay set until reset, whatever later traffic follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle bus request strobe |
| am | input | 6 | Address modifier of the request |
| addr | input | ADDR_W | Module-relative byte address |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Single-word write data |
| ack | output | 1 | Data acknowledge, one clock after an accepted request |
| rdata | output | FIFO_W | Read data, valid with `ack` |
| fifo_rd | output | 1 | Pop strobe to the output data FIFO |
| fifo_data | input | FIFO_W | Head word of the output data FIFO (show-ahead) |
| fifo_empty | input | 1 | Output data FIFO empty flag |
| scan_bytes | input | 16 | Global scan byte count from the readout logic |
| hw_status | input | 14 | Hardware status bits placed in status[15:2] |

## Verification
A fault in the AM classification shows up in the same request. It appears as a missing or extra `fifo_rd` in the request cycle, or as a missing `ack` one clock later. A corrupted message register or sticky flag stays hidden until that register or status is read back. The bench therefore reads back after every directed write and interleaves random reads with random writes. A divergence then surfaces within a few requests of the fault, in the low 16 bits of `rdata`.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    localparam int REG_W  = 16;
    localparam int OFS_W  = 14;
    localparam int BUF_W  = 5;
    localparam int CHAN_W = 4;
    localparam int AM_W   = 6;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SINGLE,
        ACC_BLOCK
    } acc_e;

    localparam logic [OFS_W-1:0] OFS_TYPE    = 14'h0000;
    localparam logic [OFS_W-1:0] OFS_SCANCNT = 14'h0004;
    localparam logic [OFS_W-1:0] OFS_STATUS  = 14'h0006;
    localparam logic [OFS_W-1:0] OFS_RDBUF   = 14'h0022;
    localparam logic [OFS_W-1:0] OFS_PIPECAP = 14'h0024;
    localparam logic [OFS_W-1:0] OFS_BX      = 14'h0026;
    localparam logic [OFS_W-1:0] OFS_SCBUF   = 14'h0028;
    localparam logic [OFS_W-1:0] OFS_EVNUM   = 14'h002A;
    localparam logic [OFS_W-1:0] OFS_MONCH   = 14'h0040;
    localparam logic [OFS_W-1:0] OFS_MONCNT  = 14'h0042;

    typedef struct packed {
        logic [BUF_W-1:0]  rd_buf;
        logic [BUF_W-1:0]  scan_buf;
        logic [CHAN_W-1:0] mon_chan;
        logic [REG_W-1:0]  pipe_cap;
        logic [REG_W-1:0]  bx_num;
        logic [REG_W-1:0]  evt_num;
        logic [REG_W-1:0]  mon_cnt;
        logic              range_err;
        logic              underrun;
    } regs_t;

endpackage

// File: rtl/vsd_am_decode.sv
module vsd_am_decode
    import vsd_pkg::*;
#(
    parameter int                          N_SINGLE   = 2,
    parameter int                          N_BLOCK    = 4,
    parameter logic [N_SINGLE*AM_W-1:0]    SINGLE_AMS = {6'h39, 6'h09},
    parameter logic [N_BLOCK*AM_W-1:0]     BLOCK_AMS  = {6'h38, 6'h3B, 6'h08, 6'h0B}
) (
    input  logic [AM_W-1:0] am,
    output acc_e            kind
);

    logic [N_SINGLE-1:0] hit_single;
    logic [N_BLOCK-1:0]  hit_block;

    generate
        for (genvar i = 0; i < N_SINGLE; i++) begin : g_single
            assign hit_single[i] = (am == SINGLE_AMS[i*AM_W +: AM_W]);
        end
        for (genvar j = 0; j < N_BLOCK; j++) begin : g_block
            assign hit_block[j] = (am == BLOCK_AMS[j*AM_W +: AM_W]);
        end
    endgenerate

    always_comb begin
        if (|hit_block) begin
            kind = ACC_BLOCK;
        end else if (|hit_single) begin
            kind = ACC_SINGLE;
        end else begin
            kind = ACC_NONE;
        end
    end

endmodule

// File: rtl/vsd_regfile.sv
module vsd_regfile
    import vsd_pkg::*;
#(
    parameter int unsigned TYPE_CODE = 3,
    parameter int unsigned CHAN_MAX  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [REG_W-1:0]  wdata,
    input  logic              underrun_set,
    input  logic [REG_W-1:0]  scan_bytes,
    input  logic [REG_W-3:0]  hw_status,
    output logic [REG_W-1:0]  rd_data
);

    localparam logic [REG_W-1:0] BUF_MAX  = REG_W'((1 << BUF_W) - 1);
    localparam logic [REG_W-1:0] CHAN_LIM = REG_W'(CHAN_MAX);
    localparam logic [REG_W-1:0] TYPE_VAL = REG_W'(TYPE_CODE);

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (ofs)
                OFS_RDBUF: begin
                    r_d.rd_buf = wdata[BUF_W-1:0];
                    if (wdata > BUF_MAX) r_d.range_err = 1'b1;
                end
                OFS_SCBUF: begin
                    r_d.scan_buf = wdata[BUF_W-1:0];
                    if (wdata > BUF_MAX) r_d.range_err = 1'b1;
                end
                OFS_MONCH: begin
                    r_d.mon_chan = wdata[CHAN_W-1:0];
                    if (wdata > CHAN_LIM) r_d.range_err = 1'b1;
                end
                OFS_PIPECAP: r_d.pipe_cap = wdata;
                OFS_BX:      r_d.bx_num   = wdata;
                OFS_EVNUM:   r_d.evt_num  = wdata;
                OFS_MONCNT:  r_d.mon_cnt  = wdata;
                default: ;
            endcase
        end
        if (underrun_set) r_d.underrun = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_TYPE:    rd_data = TYPE_VAL;
            OFS_SCANCNT: rd_data = scan_bytes;
            OFS_STATUS:  rd_data = {hw_status, r_q.underrun, r_q.range_err};
            OFS_RDBUF:   rd_data = REG_W'(r_q.rd_buf);
            OFS_SCBUF:   rd_data = REG_W'(r_q.scan_buf);
            OFS_MONCH:   rd_data = REG_W'(r_q.mon_chan);
            OFS_PIPECAP: rd_data = r_q.pipe_cap;
            OFS_BX:      rd_data = r_q.bx_num;
            OFS_EVNUM:   rd_data = r_q.evt_num;
            OFS_MONCNT:  rd_data = r_q.mon_cnt;
            default:     rd_data = '0;
        endcase
    end

    // R13
    range_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.range_err |=> r_q.range_err);

    // R13
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.underrun |=> r_q.underrun);

    // R7
    buf_range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (ofs == OFS_RDBUF || ofs == OFS_SCBUF) && wdata > BUF_MAX
        |=> r_q.range_err);

    // R8
    chan_range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && ofs == OFS_MONCH && wdata > CHAN_LIM |=> r_q.range_err);

    // R7
    rdbuf_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && ofs == OFS_RDBUF |=> r_q.rd_buf == $past(wdata[BUF_W-1:0]));

endmodule

// File: rtl/vsd_slave_decoder.sv
module vsd_slave_decoder
    import vsd_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          FIFO_W    = 32,
    parameter int unsigned TYPE_CODE = 3,
    parameter int unsigned CHAN_MAX  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [AM_W-1:0]   am,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    output logic              ack,
    output logic [FIFO_W-1:0] rdata,
    output logic              fifo_rd,
    input  logic [FIFO_W-1:0] fifo_data,
    input  logic              fifo_empty,
    input  logic [REG_W-1:0]  scan_bytes,
    input  logic [REG_W-3:0]  hw_status
);

    typedef struct packed {
        logic              ack;
        logic [FIFO_W-1:0] rdata;
    } out_t;

    out_t o_d, o_q;

    acc_e             kind;
    logic             in_win;
    logic             single_hit;
    logic             block_hit;
    logic             reg_wr;
    logic             underrun_set;
    logic [OFS_W-1:0] word_ofs;
    logic [REG_W-1:0] reg_rd;

    vsd_am_decode u_am (
        .am   (am),
        .kind (kind)
    );

    assign in_win   = (addr[ADDR_W-1:OFS_W] == '0);
    assign word_ofs = addr[OFS_W-1:0] & ~OFS_W'(1);

    vsd_regfile #(
        .TYPE_CODE (TYPE_CODE),
        .CHAN_MAX  (CHAN_MAX)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .ofs          (word_ofs),
        .wdata        (wdata),
        .underrun_set (underrun_set),
        .scan_bytes   (scan_bytes),
        .hw_status    (hw_status),
        .rd_data      (reg_rd)
    );

    always_comb begin
        single_hit   = req && (kind == ACC_SINGLE) && in_win;
        block_hit    = req && (kind == ACC_BLOCK);
        reg_wr       = single_hit && wr;
        fifo_rd      = block_hit && !wr && !fifo_empty;
        underrun_set = block_hit && !wr && fifo_empty;

        o_d       = '0;
        o_d.ack   = single_hit || block_hit;
        if (single_hit && !wr) begin
            o_d.rdata = FIFO_W'(reg_rd);
        end else if (fifo_rd) begin
            o_d.rdata = fifo_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign ack   = o_q.ack;
    assign rdata = o_q.rdata;

    // R4
    am_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && !(am inside {6'h09, 6'h39, 6'h0B, 6'h08, 6'h3B, 6'h38}) |=> !ack);

    // R4
    am_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> am inside {6'h0B, 6'h08, 6'h3B, 6'h38});

    // R2
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && (am == 6'h09 || am == 6'h39) && (addr >> OFS_W) != '0 |=> !ack);

    // R2
    ack_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req));

    // R3
    pop_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> req && !wr && !fifo_empty);

    // R3
    block_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && (am inside {6'h0B, 6'h08, 6'h3B, 6'h38}) |=> ack);

    // R11
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && !wr && fifo_empty && (am inside {6'h0B, 6'h08, 6'h3B, 6'h38})
        |=> ack && rdata == '0);

endmodule

// File: tb/vsd_slave_decoder_tb.sv
module vsd_slave_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [5:0]  am = '0;
    logic [31:0] addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic        fifo_rd;
    logic [31:0] fifo_data = '0;
    logic        fifo_empty = 1'b1;
    logic [15:0] scan_bytes = '0;
    logic [13:0] hw_status = '0;

    always #5 clk = ~clk;

    vsd_slave_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .am         (am),
        .addr       (addr),
        .wr         (wr),
        .wdata      (wdata),
        .ack        (ack),
        .rdata      (rdata),
        .fifo_rd    (fifo_rd),
        .fifo_data  (fifo_data),
        .fifo_empty (fifo_empty),
        .scan_bytes (scan_bytes),
        .hw_status  (hw_status)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model of the register state
    logic [4:0]  m_rdbuf, m_scbuf;
    logic [3:0]  m_chan;
    logic [15:0] m_pc, m_bx, m_ev, m_mc;
    logic        m_rerr, m_under;

    task automatic model_reset();
        m_rdbuf = '0; m_scbuf = '0; m_chan = '0;
        m_pc = '0; m_bx = '0; m_ev = '0; m_mc = '0;
        m_rerr = 1'b0; m_under = 1'b0;
    endtask

    function automatic int am_kind(logic [5:0] a);
        if (a == 6'h0B || a == 6'h08 || a == 6'h3B || a == 6'h38) return 2;
        if (a == 6'h09 || a == 6'h39) return 1;
        return 0;
    endfunction

    function automatic logic [15:0] exp_reg(logic [13:0] o);
        case (o)
            14'h00: return 16'd3;
            14'h04: return scan_bytes;
            14'h06: return {hw_status, m_under, m_rerr};
            14'h22: return {11'd0, m_rdbuf};
            14'h24: return m_pc;
            14'h26: return m_bx;
            14'h28: return {11'd0, m_scbuf};
            14'h2A: return m_ev;
            14'h40: return {12'd0, m_chan};
            14'h42: return m_mc;
            default: return 16'd0;
        endcase
    endfunction

    task automatic model_write(logic [13:0] o, logic [15:0] d);
        case (o)
            14'h22: begin m_rdbuf = d[4:0]; if (d > 16'd31) m_rerr = 1'b1; end
            14'h28: begin m_scbuf = d[4:0]; if (d > 16'd31) m_rerr = 1'b1; end
            14'h40: begin m_chan  = d[3:0]; if (d > 16'd9)  m_rerr = 1'b1; end
            14'h24: m_pc = d;
            14'h26: m_bx = d;
            14'h2A: m_ev = d;
            14'h42: m_mc = d;
            default: ;
        endcase
    endtask

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // one bus request; checks fifo_rd in the request cycle, ack/rdata one clock later
    task automatic access(string rq, logic [5:0] a, logic [31:0] ad, logic w,
                          logic [15:0] wd, logic [31:0] fd, logic fe);
        int          k;
        logic        e_ack, e_pop;
        logic [31:0] e_rd;
        logic [13:0] o;
        k = am_kind(a);
        o = ad[13:0] & 14'h3FFE;
        e_ack = 1'b0; e_pop = 1'b0; e_rd = '0;
        if (k == 1 && (ad >> 14) == 0) begin
            e_ack = 1'b1;
            if (!w) e_rd = {16'd0, exp_reg(o)};
        end else if (k == 2) begin
            e_ack = 1'b1;
            if (!w && !fe) begin e_pop = 1'b1; e_rd = fd; end
        end
        @(negedge clk);
        req = 1'b1; am = a; addr = ad; wr = w; wdata = wd;
        fifo_data = fd; fifo_empty = fe;
        #1;
        chk(rq, "fifo_rd", {31'd0, fifo_rd}, {31'd0, e_pop});
        @(negedge clk);
        chk(rq, "ack", {31'd0, ack}, {31'd0, e_ack});
        if (e_ack && !w) chk(rq, "rdata", rdata, e_rd);
        req = 1'b0;
        if (k == 1 && (ad >> 14) == 0 && w) model_write(o, wd);
        if (k == 2 && !w && fe) m_under = 1'b1;
    endtask

    task automatic rd(string rq, logic [31:0] ad);
        access(rq, 6'h09, ad, 1'b0, 16'h0, 32'h0, 1'b1);
    endtask

    task automatic wrr(string rq, logic [31:0] ad, logic [15:0] d);
        access(rq, 6'h39, ad, 1'b1, d, 32'h0, 1'b1);
    endtask

    localparam logic [13:0] OFS_LIST [12] = '{14'h00, 14'h02, 14'h04, 14'h06, 14'h22, 14'h24,
                                             14'h26, 14'h28, 14'h2A, 14'h30, 14'h40, 14'h42};
    localparam logic [5:0]  AM_LIST  [9]  = '{6'h09, 6'h39, 6'h0B, 6'h08, 6'h3B, 6'h38,
                                             6'h0D, 6'h3F, 6'h29};

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", "ack", {31'd0, ack}, 32'd0);
        chk("R1", "fifo_rd", {31'd0, fifo_rd}, 32'd0);
        rd("R1", 32'h06);
        rd("R1", 32'h22);
        rd("R1", 32'h40);

        // R5 type code, write ignored
        rd("R5", 32'h00);
        wrr("R5", 32'h00, 16'hFFFF);
        rd("R5", 32'h00);

        // R6 read-only count and status
        scan_bytes = 16'h1A2B; hw_status = 14'h2A5;
        rd("R6", 32'h04);
        wrr("R6", 32'h04, 16'h0);
        wrr("R6", 32'h06, 16'hFFFF);
        rd("R6", 32'h04);
        rd("R6", 32'h06);

        // R7 buffer registers
        wrr("R7", 32'h22, 16'd17);
        rd("R7", 32'h22);
        rd("R7", 32'h06);
        wrr("R7", 32'h28, 16'd31);
        rd("R7", 32'h28);
        rd("R7", 32'h06);
        wrr("R7", 32'h28, 16'd40);
        rd("R7", 32'h28);
        rd("R7", 32'h06);

        // R13 range flag persists
        wrr("R13", 32'h22, 16'd3);
        rd("R13", 32'h06);

        // R8 channel register
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; model_reset();
        wrr("R8", 32'h40, 16'd9);
        rd("R8", 32'h40);
        rd("R8", 32'h06);
        wrr("R8", 32'h40, 16'd12);
        rd("R8", 32'h40);
        rd("R8", 32'h06);

        // R9 plain registers
        wrr("R9", 32'h24, 16'hBEEF);
        wrr("R9", 32'h26, 16'h1234);
        wrr("R9", 32'h2A, 16'hA5A5);
        wrr("R9", 32'h42, 16'h00FF);
        rd("R9", 32'h24); rd("R9", 32'h26); rd("R9", 32'h2A); rd("R9", 32'h42);

        // R10 unmapped and reserved offsets
        wrr("R10", 32'h2C, 16'h5555);
        rd("R10", 32'h2C);
        wrr("R10", 32'h02, 16'hFFFF);
        rd("R10", 32'h02);
        rd("R10", 32'h3E);

        // R2 odd address, window edge
        rd("R2", 32'h25);
        rd("R2", 32'h3FFE);
        rd("R2", 32'h4024);
        wrr("R2", 32'h00014024, 16'h0);
        rd("R2", 32'h24);

        // R4 unsupported AM
        access("R4", 6'h0D, 32'h24, 1'b1, 16'h7777, 32'h0, 1'b1);
        access("R4", 6'h3F, 32'h0, 1'b0, 16'h0, 32'hDEADBEEF, 1'b0);
        rd("R4", 32'h24);

        // R3 block reads at arbitrary addresses
        access("R3", 6'h0B, 32'hFFFF0000, 1'b0, 16'h0, 32'hCAFEF00D, 1'b0);
        access("R3", 6'h08, 32'h00000022, 1'b0, 16'h0, 32'h01234567, 1'b0);
        access("R3", 6'h3B, 32'h12345678, 1'b0, 16'h0, 32'h89ABCDEF, 1'b0);
        access("R3", 6'h38, 32'h00000006, 1'b0, 16'h0, 32'hFFFFFFFF, 1'b0);

        // R12 block write
        access("R12", 6'h0B, 32'h24, 1'b1, 16'h1111, 32'h55AA55AA, 1'b0);
        rd("R12", 32'h24);

        // R11 empty read, R13 underrun persists
        access("R11", 6'h38, 32'h0, 1'b0, 16'h0, 32'h77777777, 1'b1);
        rd("R11", 32'h06);
        access("R13", 6'h0B, 32'h0, 1'b0, 16'h0, 32'h13572468, 1'b0);
        rd("R13", 32'h06);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [5:0]  a;
            logic [31:0] ad;
            logic [15:0] d;
            string       rq;
            a  = AM_LIST[$urandom_range(8, 0)];
            ad = {18'd0, OFS_LIST[$urandom_range(11, 0)]};
            if ($urandom_range(9, 0) == 0) ad = $urandom();
            if ($urandom_range(1, 0) == 1) ad[0] = 1'b1;
            d  = ($urandom_range(1, 0) == 1) ? 16'($urandom_range(40, 0)) : 16'($urandom());
            if ($urandom_range(19, 0) == 0) begin
                scan_bytes = 16'($urandom());
                hw_status  = 14'($urandom());
            end
            case (am_kind(a))
                0: rq = "R4";
                1: rq = "R2";
                default: rq = "R3";
            endcase
            access(rq, a, ad, 1'($urandom_range(1, 0)), d, $urandom(),
                   ($urandom_range(3, 0) == 0));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule